// File: doc/BRIEF.md
# Two-Channel Timer Capture/Compare Unit

This block has a 16-bit timer counter and two channels. Each channel holds one 16-bit capture/compare value. A channel works in one of two modes. In output mode it compares its value with the running counter. In input mode it samples the counter when its capture pin shows a rising edge. Each channel has one interrupt flag. The flag is set by whichever event fits the channel's current mode. The flags drive the `irq_flags` pins and can also be read in the status register.

The counter runs in one of two modes:
- **Edge mode:** it counts up and wraps.
- **Center mode:** it counts up to a reload value and then back down to zero. In center mode, compare matches do not raise flags.

Software clears a flag by writing a one to its status bit. In input mode, reading the channel's value also clears the flag.

The register port is plain control access and has no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr` while `reg_rd` is high. A read with side effects (clear on read) acts at that same edge.

Register map (byte offsets):

| Offset | Register | Contents |
|---|---|---|
| 0x00 | control | bit0 = run, bit1 = center mode, bit 2+i = channel i input mode |
| 0x04 | reload | center-mode top value, reset value 0xFFFF |
| 0x08 | status | flag of channel i at bit i |
| 0x10 + 4·i | channel i value | capture/compare value of channel i |
| 0x80 | counter | counter value |

Top module: `tmr_ccu`

## Requirements
- R1: The counter register at offset 0x80 holds a 16-bit value. It resets to 0, is writable, and reads its upper 16 bits as zero.
- R2: In edge mode with run set, the counter adds one per clock and wraps from 0xFFFF to 0. With run clear it holds its value.
- R3: In center mode with run set, the counter counts up until it reaches the reload value. It then counts down to 0 and turns up again.
- R4: A channel in output mode sets its flag one clock after a running edge-mode counter equals its compare value.
- R5: In center mode, a compare match never sets a flag.
- R6: In input mode, the capture pin passes through a two-stage synchronizer. On a rising edge, the channel latches the counter into its value register and sets its flag three clocks after the pin rises. A falling edge has no effect, and so does any edge on a channel in output mode.
- R7: Writing 1 to a status bit clears that flag. Writing 0 leaves it unchanged.
- R8: Reading a channel's value register clears its flag in input mode but not in output mode.
- R9: When a hardware set and a software clear of a flag fall in the same clock, the flag ends up set.
- R10: At reset, the registers read as follows: control 0, status 0, channel values 0, reload 0xFFFF. The `irq_flags` pins mirror the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cap_in | input | 2 | Asynchronous capture pins, one per channel |
| irq_flags | output | 2 | Per-channel interrupt flags |

## Verification
Compare is tried in three ways:
- a counter running through a programmed match in edge mode, which shows the match sets the flag;
- a center-mode run that passes the match value several times, which shows suppression;
- a wrap run from 0xFFFE, which separates wrap-around from saturation.

Capture is tried in several ways:
- a rising edge on an input-mode channel while the counter is stopped at a known value, which separates a correct latch from a stale one;
- a falling edge, and a rising edge on an output-mode channel, which must both do nothing;
- a capture timed to land on the same clock as a status clear, which shows set priority.

Reads of a channel value in each mode separate clear-on-read from a plain read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_RELOAD = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h08;
  localparam logic [ADDR_W-1:0] A_CC0    = 8'h10;
  localparam logic [ADDR_W-1:0] A_CNT    = 8'h80;
  localparam int CB_RUN    = 0;
  localparam int CB_CENTER = 1;
  localparam int CB_INMODE = 2;

  typedef enum logic {CM_EDGE = 1'b0, CM_CENTER = 1'b1} cmode_e;

  function automatic logic [ADDR_W-1:0] cc_addr(input int idx);
    return A_CC0 + ADDR_W'(4 * idx);
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  tmr_pkg::cmode_e  mode,
  input  logic             ld,
  input  logic [W-1:0]     ld_val,
  input  logic [W-1:0]     reload,
  output logic [W-1:0]     cnt
);
  import tmr_pkg::*;
  localparam logic [W-1:0] ONE = W'(1);

  logic dir_up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dir_up <= 1'b1;
    end else if (ld) begin
      cnt <= ld_val;
    end else if (run) begin
      if (mode == CM_EDGE) begin
        cnt    <= cnt + ONE;
        dir_up <= 1'b1;
      end else if (dir_up) begin
        if (cnt >= reload) begin
          dir_up <= 1'b0;
          cnt    <= (cnt == '0) ? '0 : cnt - ONE;
        end else begin
          cnt <= cnt + ONE;
        end
      end else begin
        if (cnt == '0) begin
          dir_up <= 1'b1;
          cnt    <= (reload == '0) ? '0 : ONE;
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  // R2: wrap in edge mode
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == CM_EDGE && !ld && cnt == '1) |=> (cnt == '0));

  // R2: hold while stopped
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(cnt));

  // R3: turn at the top
  p_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode == CM_CENTER && dir_up && !ld && cnt >= reload && cnt != '0)
      |=> (cnt == $past(cnt) - ONE) && !dir_up);
endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R6: a detected edge follows a rise of the synchronized level
  p_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> sh[STAGES]);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_mode,
  input  logic         center,
  input  logic         run,
  input  logic [W-1:0] cnt,
  input  logic         cap_rise,
  input  logic         wr_cc,
  input  logic [W-1:0] wdata,
  input  logic         rd_cc,
  input  logic         clr_w1,
  output logic [W-1:0] ccr,
  output logic         flag
);
  logic hit_cmp, hit_cap, set_evt, clr_evt;

  assign hit_cmp = !in_mode && !center && run && (cnt == ccr);
  assign hit_cap = in_mode && cap_rise;
  assign set_evt = hit_cmp || hit_cap;
  assign clr_evt = clr_w1 || (rd_cc && in_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr  <= '0;
      flag <= 1'b0;
    end else begin
      if (hit_cap)     ccr <= cnt;
      else if (wr_cc)  ccr <= wdata;
      if (set_evt)      flag <= 1'b1;
      else if (clr_evt) flag <= 1'b0;
    end
  end

  // R9: a set always lands
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R6: capture latches the counter
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode && cap_rise) |=> (ccr == $past(cnt)));

  // R5: no compare flag in center mode
  p_center_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (center && !in_mode && !flag) |=> !flag);

  // R8: read clears in input mode
  p_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cc && in_mode && !cap_rise) |=> !flag);
endmodule

// File: rtl/tmr_ccu.sv
module tmr_ccu #(
  parameter int CNT_W  = 16,
  parameter int NCH    = 2,
  parameter int SYNC_N = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [tmr_pkg::ADDR_W-1:0]  reg_addr,
  input  logic [tmr_pkg::DATA_W-1:0]  reg_wdata,
  output logic [tmr_pkg::DATA_W-1:0]  reg_rdata,
  input  logic [NCH-1:0]              cap_in,
  output logic [NCH-1:0]              irq_flags
);
  import tmr_pkg::*;
  localparam int CTRL_W = CB_INMODE + NCH;

  logic [CTRL_W-1:0] ctrl;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  ccr [NCH];
  logic [NCH-1:0]    cap_rise;
  logic              run, center;
  cmode_e            mode;
  logic              ld_cnt;
  logic              unused_wdata;

  assign run    = ctrl[CB_RUN];
  assign center = ctrl[CB_CENTER];
  assign mode   = center ? CM_CENTER : CM_EDGE;
  assign ld_cnt = reg_wr && (reg_addr == A_CNT);
  assign unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '1;
    end else if (reg_wr) begin
      if (reg_addr == A_CTRL)   ctrl   <= reg_wdata[CTRL_W-1:0];
      if (reg_addr == A_RELOAD) reload <= reg_wdata[CNT_W-1:0];
    end
  end

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode),
    .ld(ld_cnt), .ld_val(reg_wdata[CNT_W-1:0]), .reload(reload), .cnt(cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_cc;
    assign sel_cc = (reg_addr == cc_addr(i));

    tmr_sync_edge #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in[i]), .rise(cap_rise[i])
    );

    tmr_channel #(.W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .in_mode(ctrl[CB_INMODE+i]), .center(center), .run(run),
      .cnt(cnt), .cap_rise(cap_rise[i]),
      .wr_cc(reg_wr && sel_cc), .wdata(reg_wdata[CNT_W-1:0]),
      .rd_cc(reg_rd && sel_cc),
      .clr_w1(reg_wr && (reg_addr == A_STAT) && reg_wdata[i]),
      .ccr(ccr[i]), .flag(irq_flags[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL)   reg_rdata[CTRL_W-1:0] = ctrl;
    if (reg_addr == A_RELOAD) reg_rdata[CNT_W-1:0]  = reload;
    if (reg_addr == A_STAT)   reg_rdata[NCH-1:0]    = irq_flags;
    if (reg_addr == A_CNT)    reg_rdata[CNT_W-1:0]  = cnt;
    for (int i = 0; i < NCH; i++)
      if (reg_addr == cc_addr(i)) reg_rdata[CNT_W-1:0] = ccr[i];
  end

  // R1: counter load is visible next cycle
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> (cnt == $past(reg_wdata[CNT_W-1:0])));
endmodule

// File: tb/test_tmr_ccu.sv
module test_tmr_ccu;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_RELOAD = 8'h04, A_STAT = 8'h08,
                         A_CC0 = 8'h10, A_CC1 = 8'h14, A_CNT = 8'h80;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [1:0]  cap_in = 0;
  logic [1:0]  irq_flags;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_ccu i_tmr_ccu (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_in(cap_in), .irq_flags(irq_flags)
  );

  // monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    if (reg_rd && !done) begin
      total++;
      if (q_exp.size() == 0) begin
        bad++;
        $display("FAIL unexpected read: actual=%h expected=none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (reg_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    q_exp.push_back(e); q_tag.push_back(t);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  // counts exactly extra+2 edges with run set
  task automatic run_for(input logic [31:0] bits, input int extra);
    reg_write(A_CTRL, bits | 32'h1);
    repeat (extra) @(posedge clk);
    reg_write(A_CTRL, bits);
  endtask

  task automatic check_pin(input logic [1:0] e, input string t);
    @(negedge clk);
    total++;
    if (irq_flags !== e) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", t, irq_flags, e);
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 / R1 reset state
    reg_read(A_CTRL,   32'h0,     "R10 ctrl reset");
    reg_read(A_STAT,   32'h0,     "R10 status reset");
    reg_read(A_RELOAD, 32'hFFFF,  "R10 reload reset");
    reg_read(A_CC0,    32'h0,     "R10 cc0 reset");
    reg_read(A_CNT,    32'h0,     "R1 counter reset");
    // R1 write, upper half reads zero
    reg_write(A_CNT, 32'hABCD1234);
    reg_read(A_CNT, 32'h00001234, "R1 counter write");
    // R2 wrap: 0xFFFE + 2 counts
    reg_write(A_CNT, 32'hFFFE);
    run_for(32'h0, 0);
    reg_read(A_CNT, 32'h0, "R2 wrap");
    repeat (5) @(posedge clk);
    reg_read(A_CNT, 32'h0, "R2 hold when stopped");
    // R4 compare: 0x0E + 3 counts passes 0x10
    reg_write(A_CC0, 32'h0010);
    reg_write(A_CC1, 32'h0050);
    reg_write(A_CNT, 32'h000E);
    run_for(32'h0, 1);
    reg_read(A_CNT, 32'h0011, "R2 count up");
    reg_read(A_STAT, 32'h1, "R4 compare match");
    reg_read(A_CC0, 32'h0010, "R8 output read");
    reg_read(A_STAT, 32'h1, "R8 output read keeps flag");
    // R7 write-one-to-clear
    reg_write(A_STAT, 32'h0);
    reg_read(A_STAT, 32'h1, "R7 write zero no effect");
    reg_write(A_STAT, 32'h1);
    reg_read(A_STAT, 32'h0, "R7 write one clears");
    // R3/R5 center: 2 +7 counts with top 4 -> 3,4,3,2,1,0,1
    reg_write(A_RELOAD, 32'h4);
    reg_write(A_CNT, 32'h2);
    reg_write(A_CC0, 32'h3);
    run_for(32'h2, 5);
    reg_read(A_CNT, 32'h1, "R3 center up/down");
    reg_read(A_STAT, 32'h0, "R5 center suppresses compare");
    // R6 capture on channel 1 (input mode bit 3), counter stopped
    reg_write(A_CTRL, 32'h8);
    reg_write(A_CNT, 32'h0ABC);
    @(posedge clk); #1 cap_in[1] = 1;
    repeat (4) @(posedge clk);
    reg_read(A_STAT, 32'h2, "R6 capture flag");
    check_pin(2'b10, "R10 pins mirror status");
    reg_read(A_CC1, 32'h0ABC, "R6 capture value");
    reg_read(A_STAT, 32'h0, "R8 input read clears");
    @(posedge clk); #1 cap_in[1] = 0;
    repeat (4) @(posedge clk);
    reg_read(A_STAT, 32'h0, "R6 falling edge ignored");
    // R6 edge on an output-mode channel
    @(posedge clk); #1 cap_in[0] = 1;
    repeat (4) @(posedge clk);
    reg_read(A_STAT, 32'h0, "R6 output mode no capture flag");
    reg_read(A_CC0, 32'h3, "R6 output mode no latch");
    // R9 capture lands on the same edge as a status clear
    reg_write(A_CNT, 32'h0777);
    repeat (3) @(posedge clk);
    #1 cap_in[1] = 1;
    @(posedge clk);
    reg_write(A_STAT, 32'h2);
    reg_read(A_STAT, 32'h2, "R9 set beats clear");
    reg_read(A_CC1, 32'h0777, "R9 capture value");
    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule